// File: doc/BRIEF.md
# Handshake Word Clock-Domain Synchronizer

This block carries a multi-bit word from one clock domain into a second clock domain that has no known frequency or phase relation to the first. The receiver always sees a whole word, never a mix of old and new bits. Each side has its own clock, its own synchronous clear and its own valid/ready handshake. A completed sending handshake stores the word in a holding register and flips a one-bit request toggle. The toggle is synchronized into the receiving domain, where the stored word is copied into a single-entry output register. An acknowledge toggle then travels back the same way, and only after it arrives does the sending side accept its next word.

Because the stored word does not change while a request is outstanding, only the two toggle bits pass through synchronizer flip-flops. The depth of both synchronizer chains is two stages plus a parameter. With sending valid tied high and receiving valid fed back into receiving ready, the block samples a changing value continuously, as fast as round trips complete. In that mode the received value always lags the sender's current value.

Top module: `cdc_word_xfer`

## Requirements
- R1: After a clear of both sides, `snd_ready` is 1, `rcv_valid` is 0 and `rcv_data` is all zeros. No word that was accepted before the clear is presented afterwards.
- R2: A sending handshake is `snd_valid` and `snd_ready` both high at a rising `snd_clk` edge. From the next sending cycle, `snd_ready` is 0, and it returns to 1 once the acknowledge has crossed back.
- R3: The word captured at the sending handshake is the word delivered. Later changes on `snd_data`, while `snd_ready` is 0, have no effect on it.
- R4: `rcv_data` equals the captured word in every bit position, including all-ones and alternating patterns.
- R5: With the output register empty, `rcv_valid` goes high between STAGES+1 and STAGES+2 rising `rcv_clk` edges after the sending handshake edge, where STAGES = 2 + EXTRA_STAGES.
- R6: While `rcv_valid` is 1 and `rcv_ready` is 0, `rcv_valid` stays 1 and `rcv_data` does not change.
- R7: A receiving handshake (`rcv_valid` and `rcv_ready` high at a rising `rcv_clk` edge) makes `rcv_valid` 0 in the next receiving cycle, and `rcv_data` keeps the consumed word.
- R8: A word sent while the previous word is still unconsumed does not replace it. `snd_ready` stays 0 until the second word has been loaded, and that word appears only after the first has been consumed.
- R9: With `snd_valid` held at 1 and `rcv_ready` driven from `rcv_valid`, transfers repeat without further stimulus, and each received word is strictly greater than the one before when the sender presents a rising count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending-side clock |
| snd_clr | input | 1 | Sending-side synchronous clear, active high |
| snd_valid | input | 1 | Sender offers a word |
| snd_ready | output | 1 | Block can take a word |
| snd_data | input | WIDTH | Word offered by the sender |
| rcv_clk | input | 1 | Receiving-side clock |
| rcv_clr | input | 1 | Receiving-side synchronous clear, active high |
| rcv_valid | output | 1 | Output register holds an unconsumed word |
| rcv_ready | input | 1 | Receiver takes the presented word |
| rcv_data | output | WIDTH | Received word |

## Verification
Two results have exact timing. `snd_ready` falls one sending cycle after the sending handshake, and `rcv_valid` falls one receiving cycle after the receiving handshake. The bench samples both at the falling edge of the clock that follows. The arrival of `rcv_valid` depends on the phase between the two clocks. The bench therefore counts receiving rising edges from the sending handshake edge with a separate counter, accepts STAGES+1 to STAGES+2, and waits for arrival with a bounded loop. The two clocks are offset so that their edges never coincide, which keeps the edge counts free of ordering races. Checks for "no effect" wait a fixed number of receiving cycles, well past any round trip, before they read the outputs.

// File: rtl/cdcw_pkg.sv
`timescale 1ns/10ps
package cdcw_pkg;

    // Minimum synchronizer flip-flops on every toggle crossing.
    localparam int unsigned CDCW_MIN_STAGES = 2;

    // Two toggles that differ mean one request (or acknowledge) is outstanding.
    function automatic logic tgl_pending(input logic a, input logic b);
        return a ^ b;
    endfunction

endpackage

// File: rtl/cdcw_sync_bit.sv
`timescale 1ns/10ps
module cdcw_sync_bit #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end else begin : g_single
            always_comb chain_d = d;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdcw_send.sv
`timescale 1ns/10ps
module cdcw_send
    import cdcw_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned EXTRA_STAGES = 0
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             valid,
    output logic             ready,
    input  logic [WIDTH-1:0] data,
    input  logic             ack_async,
    output logic             req_tgl,
    output logic [WIDTH-1:0] word
);

    localparam int unsigned STAGES = CDCW_MIN_STAGES + EXTRA_STAGES;

    typedef struct packed {
        logic             req;
        logic [WIDTH-1:0] word;
    } snd_st_t;

    snd_st_t st_d;
    snd_st_t st_q;
    logic    ack_s;
    logic    take;

    cdcw_sync_bit #(.STAGES(STAGES)) u_ack_sync (
        .clk (clk),
        .clr (clr),
        .d   (ack_async),
        .q   (ack_s)
    );

    always_comb begin
        st_d  = st_q;
        ready = !tgl_pending(st_q.req, ack_s);
        take  = valid && ready;
        if (take) begin
            st_d.word = data;
            st_d.req  = ~st_q.req;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_tgl = st_q.req;
    assign word    = st_q.word;

endmodule

// File: rtl/cdcw_recv.sv
`timescale 1ns/10ps
module cdcw_recv
    import cdcw_pkg::*;
#(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned EXTRA_STAGES = 0
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             req_async,
    input  logic [WIDTH-1:0] word_in,
    output logic             valid,
    input  logic             ready,
    output logic [WIDTH-1:0] data,
    output logic             ack_tgl
);

    localparam int unsigned STAGES = CDCW_MIN_STAGES + EXTRA_STAGES;

    typedef struct packed {
        logic             ack;
        logic             vld;
        logic [WIDTH-1:0] word;
    } rcv_st_t;

    rcv_st_t st_d;
    rcv_st_t st_q;
    logic    req_s;
    logic    pend;

    cdcw_sync_bit #(.STAGES(STAGES)) u_req_sync (
        .clk (clk),
        .clr (clr),
        .d   (req_async),
        .q   (req_s)
    );

    always_comb begin
        st_d = st_q;
        pend = tgl_pending(req_s, st_q.ack);
        if (st_q.vld && ready) begin
            st_d.vld = 1'b0;
        end
        // Load only into an empty register; an unconsumed word is never replaced.
        if (pend && !st_q.vld) begin
            st_d.word = word_in;
            st_d.vld  = 1'b1;
            st_d.ack  = ~st_q.ack;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid   = st_q.vld;
    assign data    = st_q.word;
    assign ack_tgl = st_q.ack;

endmodule

// File: rtl/cdc_word_xfer.sv
`timescale 1ns/10ps
module cdc_word_xfer #(
    parameter int unsigned WIDTH        = 8,
    parameter int unsigned EXTRA_STAGES = 0
) (
    input  logic             snd_clk,
    input  logic             snd_clr,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic [WIDTH-1:0] snd_data,
    input  logic             rcv_clk,
    input  logic             rcv_clr,
    output logic             rcv_valid,
    input  logic             rcv_ready,
    output logic [WIDTH-1:0] rcv_data
);

    logic             req_tgl;
    logic             ack_tgl;
    logic [WIDTH-1:0] xfer_word;

    cdcw_send #(.WIDTH(WIDTH), .EXTRA_STAGES(EXTRA_STAGES)) u_snd (
        .clk       (snd_clk),
        .clr       (snd_clr),
        .valid     (snd_valid),
        .ready     (snd_ready),
        .data      (snd_data),
        .ack_async (ack_tgl),
        .req_tgl   (req_tgl),
        .word      (xfer_word)
    );

    cdcw_recv #(.WIDTH(WIDTH), .EXTRA_STAGES(EXTRA_STAGES)) u_rcv (
        .clk       (rcv_clk),
        .clr       (rcv_clr),
        .req_async (req_tgl),
        .word_in   (xfer_word),
        .valid     (rcv_valid),
        .ready     (rcv_ready),
        .data      (rcv_data),
        .ack_tgl   (ack_tgl)
    );

endmodule

// File: rtl/cdc_word_xfer_chk.sv
`timescale 1ns/10ps
module cdc_word_xfer_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             snd_clk,
    input logic             snd_clr,
    input logic             snd_valid,
    input logic             snd_ready,
    input logic [WIDTH-1:0] xfer_word,
    input logic             rcv_clk,
    input logic             rcv_clr,
    input logic             rcv_valid,
    input logic             rcv_ready,
    input logic [WIDTH-1:0] rcv_data
);

    assert_clear_snd_R1: assert property (@(posedge snd_clk) disable iff (snd_clr)
        $past(snd_clr) |-> snd_ready);

    assert_clear_rcv_R1: assert property (@(posedge rcv_clk) disable iff (rcv_clr)
        $past(rcv_clr) |-> !rcv_valid);

    assert_ready_drop_R2: assert property (@(posedge snd_clk) disable iff (snd_clr)
        (snd_valid && snd_ready) |=> !snd_ready);

    assert_hold_stable_R3: assert property (@(posedge snd_clk) disable iff (snd_clr)
        !snd_ready |=> $stable(xfer_word));

    assert_out_steady_R6: assert property (@(posedge rcv_clk) disable iff (rcv_clr)
        (rcv_valid && !rcv_ready) |=> (rcv_valid && $stable(rcv_data)));

    assert_valid_drop_R7: assert property (@(posedge rcv_clk) disable iff (rcv_clr)
        (rcv_valid && rcv_ready) |=> (!rcv_valid && $stable(rcv_data)));

endmodule

bind cdc_word_xfer cdc_word_xfer_chk #(.WIDTH(WIDTH)) u_chk (
    .snd_clk   (snd_clk),
    .snd_clr   (snd_clr),
    .snd_valid (snd_valid),
    .snd_ready (snd_ready),
    .xfer_word (xfer_word),
    .rcv_clk   (rcv_clk),
    .rcv_clr   (rcv_clr),
    .rcv_valid (rcv_valid),
    .rcv_ready (rcv_ready),
    .rcv_data  (rcv_data)
);

// File: tb/cdc_word_xfer_test.sv
`timescale 1ns/10ps
module cdc_word_xfer_test;

    localparam int unsigned WIDTH  = 8;
    localparam int unsigned EXTRA  = 1;
    localparam int unsigned STAGES = 2 + EXTRA;
    localparam int NVEC = 6;
    // {word, receiving cycles to hold off before consuming}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h3C, 4'd0}, {8'hFF, 4'd3}, {8'hA5, 4'd1},
        {8'h5A, 4'd5}, {8'h01, 4'd0}, {8'h80, 4'd2}
    };

    logic             snd_clk = 1'b0;
    logic             rcv_clk = 1'b0;
    logic             snd_clr = 1'b1;
    logic             rcv_clr = 1'b1;
    logic             snd_valid = 1'b0;
    logic [WIDTH-1:0] snd_data = '0;
    logic             rcv_ready_drv = 1'b0;
    logic             stream_mode = 1'b0;
    logic             snd_ready;
    logic             rcv_valid;
    logic             rcv_ready;
    logic [WIDTH-1:0] rcv_data;

    int tests = 0;
    int fails = 0;
    int edges_since = 0;
    bit done = 1'b0;

    assign rcv_ready = stream_mode ? rcv_valid : rcv_ready_drv;

    cdc_word_xfer #(.WIDTH(WIDTH), .EXTRA_STAGES(EXTRA)) uut (
        .snd_clk   (snd_clk),
        .snd_clr   (snd_clr),
        .snd_valid (snd_valid),
        .snd_ready (snd_ready),
        .snd_data  (snd_data),
        .rcv_clk   (rcv_clk),
        .rcv_clr   (rcv_clr),
        .rcv_valid (rcv_valid),
        .rcv_ready (rcv_ready),
        .rcv_data  (rcv_data)
    );

    // 50 MHz sending clock; receiving clock offset so edges never coincide.
    always #10 snd_clk = ~snd_clk;
    initial begin
        #3.05;
        forever #7.3 rcv_clk = ~rcv_clk;
    end

    always @(posedge rcv_clk) edges_since = edges_since + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [WIDTH-1:0] w);
        @(negedge snd_clk);
        snd_valid = 1'b1;
        snd_data  = w;
        while (!snd_ready) @(negedge snd_clk);
        @(posedge snd_clk);
        edges_since = 0;
        @(negedge snd_clk);
        snd_valid = 1'b0;
        snd_data  = ~w;            // ignored after capture (R3)
    endtask

    task automatic wait_valid(output int lat);
        int n = 0;
        @(negedge rcv_clk);
        while (!rcv_valid && n < 200) begin
            @(negedge rcv_clk);
            n++;
        end
        lat = edges_since;
    endtask

    task automatic consume();
        @(negedge rcv_clk);
        rcv_ready_drv = 1'b1;
        @(negedge rcv_clk);
        rcv_ready_drv = 1'b0;
    endtask

    task automatic clear_both();
        @(negedge snd_clk);
        snd_clr = 1'b1;
        rcv_clr = 1'b1;
        repeat (4) @(negedge snd_clk);
        snd_clr = 1'b0;
        rcv_clr = 1'b0;
    endtask

    initial begin : watchdog
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog (run did not complete) actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        int lat;
        logic [WIDTH-1:0] last;
        int ngot;
        int bad;

        clear_both();
        @(negedge snd_clk);
        chk(snd_ready == 1'b1, "R1 ready after clear", snd_ready, 1);
        @(negedge rcv_clk);
        chk(rcv_valid == 1'b0, "R1 valid after clear", rcv_valid, 0);
        chk(rcv_data == '0, "R1 data after clear", rcv_data, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [WIDTH-1:0] w;
            int hold;
            w    = VEC[i][11:4];
            hold = int'(VEC[i][3:0]);
            push(w);
            chk(snd_ready == 1'b0, "R2 ready low after handshake", snd_ready, 0);
            wait_valid(lat);
            chk(lat >= STAGES + 1 && lat <= STAGES + 2, "R5 latency", lat, STAGES + 1);
            chk(rcv_data == w, "R4 word intact", rcv_data, w);
            chk(rcv_data == w, "R3 later input ignored", rcv_data, w);
            for (int k = 0; k < hold; k++) begin
                @(negedge rcv_clk);
                chk(rcv_valid && rcv_data == w, "R6 held while not ready", rcv_data, w);
            end
            consume();
            chk(rcv_valid == 1'b0, "R7 valid drops", rcv_valid, 0);
            chk(rcv_data == w, "R7 data kept", rcv_data, w);
            repeat (20) @(negedge snd_clk);
            chk(snd_ready == 1'b1, "R2 ready returns", snd_ready, 1);
        end

        // R8: second word must not overwrite an unconsumed first word
        push(8'hC3);
        wait_valid(lat);
        push(8'h96);
        repeat (30) @(negedge rcv_clk);
        chk(rcv_valid && rcv_data == 8'hC3, "R8 first word kept", rcv_data, 8'hC3);
        @(negedge snd_clk);
        chk(snd_ready == 1'b0, "R8 sender held back", snd_ready, 0);
        consume();
        chk(rcv_valid == 1'b0, "R7 valid drops before next", rcv_valid, 0);
        wait_valid(lat);
        chk(rcv_valid && rcv_data == 8'h96, "R8 second word after consume", rcv_data, 8'h96);
        consume();

        // R9: free-running sampling of a rising count
        @(negedge snd_clk);
        stream_mode = 1'b1;
        snd_valid   = 1'b1;
        snd_data    = 8'd1;
        ngot = 0;
        bad  = 0;
        last = '0;
        fork
            begin
                repeat (115) begin
                    @(negedge snd_clk);
                    snd_data = snd_data + 8'd1;
                end
            end
            begin
                repeat (150) begin
                    @(negedge rcv_clk);
                    if (rcv_valid) begin
                        if (ngot > 0 && rcv_data <= last) bad++;
                        last = rcv_data;
                        ngot++;
                    end
                end
            end
        join
        snd_valid = 1'b0;
        chk(bad == 0, "R9 strictly increasing samples", bad, 0);
        chk(ngot >= 5, "R9 transfers repeat", ngot, 5);
        repeat (40) @(negedge rcv_clk);
        stream_mode = 1'b0;

        // R1: clear while a word is in flight
        push(8'h77);
        clear_both();
        @(negedge snd_clk);
        chk(snd_ready == 1'b1, "R1 ready after mid-flight clear", snd_ready, 1);
        bad = 0;
        repeat (30) begin
            @(negedge rcv_clk);
            if (rcv_valid) bad++;
        end
        chk(bad == 0, "R1 no stale word after clear", bad, 0);
        chk(rcv_data == '0, "R1 data zero after clear", rcv_data, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule